// File: doc/BRIEF.md
# Indirect-Access Interrupt Redirection Unit

This block routes a set of external interrupt lines to interrupt vectors. Software reaches its registers through a pair of 32-bit memory-mapped words. One word holds a register index (the select word). The other is a data window that reads or writes whichever register the select word names. The registers behind the window are:

- an identification register;
- a read-only version register;
- an arbitration register that always reads as zero;
- a redirection table with one two-word entry per input line.

Each input line is edge-detected. On a rising edge, the block looks at the low word of that line's entry. If the entry's mask bit is clear, the line becomes pending. Pending lines go out, lowest-numbered first, as an 8-bit vector on a valid/ready delivery port. All entries come out of reset masked, so nothing is delivered until software unmasks a line.

Top module: `irq_router`

## Requirements
- R1: A write at byte offset 0x10 (the window) acts on the register whose index is held in the select word at byte offset 0x00. A read at any offset other than 0x10, including 0x00, returns 0. A write at any offset other than 0x00 or 0x10 changes nothing.
- R2: Index 0 is the identification register. After reset it reads 0. A write loads the ID from data bits 31:24. A read returns the ID in bits 31:24 and zero in all other bits.
- R3: Index 1 is read-only and reads 0x00170011: the value 0x11 in bits 7:0 and the highest entry number (23) in bits 23:16. Writes to index 1 have no effect.
- R4: Index 2 reads 0, and writes to it have no effect.
- R5: Entry n (0 to 23) has its low word at index 0x10+2n and its high word at index 0x11+2n. Both words read back exactly as last written. In the low word, bits 7:0 are the vector and bit 16 is the mask. Bits 10:8, 11 and 15 hold the delivery mode, destination mode and trigger mode. In the high word, bits 31:24 hold the destination.
- R6: After reset, every low word reads 0x00010000 (masked), and the delivery port is idle.
- R7: Reading any index outside {0, 1, 2, 0x10..0x3F} returns 0, and writing such an index changes no register.
- R8: A rising edge on an unmasked line sets dlv_valid, with dlv_vector equal to bits 7:0 of that line's low word, after the second rising clock edge from the first edge that samples the line high. The transfer completes on a clock edge where dlv_ready is high. A line held high delivers only once.
- R9: A rising edge on a line whose low word has bit 16 set delivers nothing.
- R10: When several lines rise in the same cycle, the lowest-numbered line is delivered first and the others stay pending. While dlv_valid is high and dlv_ready is low, dlv_valid and dlv_vector hold steady.
- R11: Read data appears on bus_rdata after the clock edge that samples bus_rd, and stays there until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one 32-bit access |
| bus_rd | input | 1 | Read strobe for one 32-bit access |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_in | input | NUM_LINES | External interrupt lines, active high |
| dlv_valid | output | 1 | A vector is on offer |
| dlv_vector | output | 8 | Vector being delivered |
| dlv_ready | input | 1 | The consumer accepts the vector on this clock edge |

## Verification
Each bus access takes one clock edge. Its read result is due one edge after bus_rd is sampled, so the bench drives on the falling edge and samples bus_rdata at the next falling edge. An interrupt edge takes two register stages to reach the delivery port: the edge detector and pending bit, then the output register. The bench therefore raises a line on a falling edge and checks dlv_valid low after the first rising edge and high after the second. It then checks each later vector one edge after the acceptance that frees the output register. Register readback is swept over all 256 select values, before and after every index is written, against a model of the map kept in the bench.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int WORD_W      = 32;
  localparam int VEC_W       = 8;
  localparam int MASK_BIT    = 16;
  localparam int ID_LSB      = 24;
  localparam int IDX_ID      = 0;
  localparam int IDX_VER     = 1;
  localparam int IDX_ARB     = 2;
  localparam int TABLE_BASE  = 16;
  localparam logic [7:0] VERSION_CODE = 8'h11;

  function automatic logic [WORD_W-1:0] lo_reset_word();
    logic [WORD_W-1:0] w;
    w = '0;
    w[MASK_BIT] = 1'b1;
    return w;
  endfunction
endpackage

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_router_pkg::*;
#(
  parameter int NUM_LINES = 24,
  parameter int ADDR_W    = 8,
  parameter int SEL_W     = 8,
  parameter int SEL_OFFS  = 0,
  parameter int WIN_OFFS  = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           bus_wr,
  input  logic                           bus_rd,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [WORD_W-1:0]              bus_wdata,
  output logic [WORD_W-1:0]              bus_rdata,
  output logic [NUM_LINES-1:0]           line_mask,
  output logic [NUM_LINES-1:0][VEC_W-1:0] line_vec
);
  localparam int ENTRY_W   = $clog2(NUM_LINES);
  localparam int TABLE_END = TABLE_BASE + 2 * NUM_LINES;

  logic [SEL_W-1:0]  sel_q;
  logic [7:0]        id_q;
  logic [WORD_W-1:0] lo_q [NUM_LINES];
  logic [WORD_W-1:0] hi_mem [NUM_LINES];
  logic [WORD_W-1:0] hi_rd_q;
  logic [WORD_W-1:0] data_q;
  logic              use_ram_q;

  logic              sel_hit, win_hit, in_table, is_hi;
  logic [SEL_W-1:0]  rel;
  logic [ENTRY_W-1:0] entry;
  logic [WORD_W-1:0] rd_value;

  assign sel_hit  = (bus_addr == ADDR_W'(SEL_OFFS));
  assign win_hit  = (bus_addr == ADDR_W'(WIN_OFFS));
  assign in_table = (int'(sel_q) >= TABLE_BASE) && (int'(sel_q) < TABLE_END);
  assign is_hi    = sel_q[0];
  assign rel      = sel_q - SEL_W'(TABLE_BASE);
  assign entry    = rel[ENTRY_W:1];

  // Select word
  always_ff @(posedge clk) begin
    if (rst)
      sel_q <= '0;
    else if (bus_wr && sel_hit)
      sel_q <= bus_wdata[SEL_W-1:0];
  end

  // Identification register
  always_ff @(posedge clk) begin
    if (rst)
      id_q <= '0;
    else if (bus_wr && win_hit && (int'(sel_q) == IDX_ID))
      id_q <= bus_wdata[ID_LSB +: 8];
  end

  // Low words: flops, reset to masked, visible in parallel to the datapath
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_lo
    always_ff @(posedge clk) begin
      if (rst)
        lo_q[i] <= lo_reset_word();
      else if (bus_wr && win_hit && in_table && !is_hi && (entry == ENTRY_W'(i)))
        lo_q[i] <= bus_wdata;
    end
    assign line_mask[i] = lo_q[i][MASK_BIT];
    assign line_vec[i]  = lo_q[i][VEC_W-1:0];
  end

  // High words: single-port memory, no reset, registered read
  always_ff @(posedge clk) begin
    if (bus_wr && win_hit && in_table && is_hi)
      hi_mem[entry] <= bus_wdata;
    if (bus_rd && win_hit && in_table && is_hi)
      hi_rd_q <= hi_mem[entry];
  end

  always_comb begin
    rd_value = '0;
    if (win_hit) begin
      if (int'(sel_q) == IDX_ID)
        rd_value = {id_q, 24'h0};
      else if (int'(sel_q) == IDX_VER)
        rd_value = {8'h00, 8'(NUM_LINES - 1), 8'h00, VERSION_CODE};
      else if (int'(sel_q) == IDX_ARB)
        rd_value = '0;
      else if (in_table && !is_hi)
        rd_value = lo_q[entry];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q    <= '0;
      use_ram_q <= 1'b0;
    end else if (bus_rd) begin
      data_q    <= rd_value;
      use_ram_q <= win_hit && in_table && is_hi;
    end
  end

  assign bus_rdata = use_ram_q ? hi_rd_q : data_q;
endmodule

// File: rtl/irq_edge_pend.sv
module irq_edge_pend #(
  parameter int NUM_LINES = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic [NUM_LINES-1:0] line_mask,
  input  logic                 take,
  input  logic [NUM_LINES-1:0] grant,
  output logic [NUM_LINES-1:0] pend
);
  logic [NUM_LINES-1:0] irq_q;
  logic [NUM_LINES-1:0] rise;

  always_ff @(posedge clk) begin
    if (rst)
      irq_q <= '0;
    else
      irq_q <= irq_in;
  end

  assign rise = irq_in & ~irq_q;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_pend
    always_ff @(posedge clk) begin
      if (rst)
        pend[i] <= 1'b0;
      else
        pend[i] <= (pend[i] & ~(take & grant[i])) | (rise[i] & ~line_mask[i]);
    end
  end
endmodule

// File: rtl/irq_lowest_first.sv
module irq_lowest_first #(
  parameter int NUM_LINES = 24,
  localparam int ENTRY_W  = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0] req,
  output logic [NUM_LINES-1:0] grant,
  output logic [ENTRY_W-1:0]   idx
);
  logic [NUM_LINES:0] blocked;

  assign blocked[0] = 1'b0;
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_chain
    assign grant[i]     = req[i] & ~blocked[i];
    assign blocked[i+1] = blocked[i] | req[i];
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < NUM_LINES; i++)
      if (grant[i])
        idx = idx | ENTRY_W'(i);
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_LINES = 24,
  parameter int ADDR_W    = 8,
  parameter int SEL_W     = 8,
  parameter int SEL_OFFS  = 0,
  parameter int WIN_OFFS  = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_LINES-1:0] irq_in,
  output logic                 dlv_valid,
  output logic [7:0]           dlv_vector,
  input  logic                 dlv_ready
);
  localparam int ENTRY_W = $clog2(NUM_LINES);

  logic [NUM_LINES-1:0]            line_mask;
  logic [NUM_LINES-1:0][VEC_W-1:0] line_vec;
  logic [NUM_LINES-1:0]            pend;
  logic [NUM_LINES-1:0]            grant;
  logic [ENTRY_W-1:0]              grant_idx;
  logic                            take;

  irq_regfile #(
    .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .SEL_W(SEL_W),
    .SEL_OFFS(SEL_OFFS), .WIN_OFFS(WIN_OFFS)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .line_mask(line_mask), .line_vec(line_vec)
  );

  irq_edge_pend #(.NUM_LINES(NUM_LINES)) u_pend (
    .clk(clk), .rst(rst), .irq_in(irq_in), .line_mask(line_mask),
    .take(take), .grant(grant), .pend(pend)
  );

  irq_lowest_first #(.NUM_LINES(NUM_LINES)) u_arb (
    .req(pend), .grant(grant), .idx(grant_idx)
  );

  // Output register is free when empty or being accepted this edge
  assign take = !dlv_valid || dlv_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      dlv_valid  <= 1'b0;
      dlv_vector <= '0;
    end else if (take) begin
      dlv_valid <= |pend;
      if (|pend)
        dlv_vector <= line_vec[grant_idx];
    end
  end
endmodule

// File: rtl/irq_router_checker.sv
module irq_router_checker #(
  parameter int NUM_LINES = 24,
  parameter int ADDR_W    = 8,
  parameter int WIN_OFFS  = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_rd,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [31:0]          bus_rdata,
  input logic                 dlv_valid,
  input logic [7:0]           dlv_vector,
  input logic                 dlv_ready,
  input logic [NUM_LINES-1:0] pend,
  input logic [NUM_LINES-1:0] grant
);
  assert_offwin_zero_R1: assert property (@(posedge clk) disable iff (rst)
    bus_rd && (bus_addr != ADDR_W'(WIN_OFFS)) |=> bus_rdata == 32'h0);

  assert_reset_idle_R6: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !dlv_valid);

  assert_drain_R8: assert property (@(posedge clk) disable iff (rst)
    dlv_valid && dlv_ready && (pend == '0) |=> !dlv_valid);

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    dlv_valid && !dlv_ready |=> dlv_valid && $stable(dlv_vector));

  assert_grant_onehot_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  assert_grant_present_R10: assert property (@(posedge clk) disable iff (rst)
    (pend != '0) |-> (grant != '0));
endmodule

bind irq_router irq_router_checker #(
  .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .WIN_OFFS(WIN_OFFS)
) u_chk (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .dlv_valid(dlv_valid), .dlv_vector(dlv_vector),
  .dlv_ready(dlv_ready), .pend(pend), .grant(grant)
);

// File: tb/irq_router_test.sv
module irq_router_test;
  localparam int N = 24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] irq_in = '0;
  logic        dlv_valid;
  logic [7:0]  dlv_vector;
  logic        dlv_ready = 1'b1;

  int checks = 0;
  int errors = 0;

  logic [31:0] lo_m [N];
  logic [31:0] hi_m [N];
  logic [7:0]  id_m;

  always #4 clk = ~clk;

  irq_router uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_in(irq_in), .dlv_valid(dlv_valid), .dlv_vector(dlv_vector),
    .dlv_ready(dlv_ready)
  );

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  function automatic logic [31:0] model_read(int s);
    if (s == 0) return {id_m, 24'h0};
    if (s == 1) return 32'h0017_0011;
    if (s == 2) return 32'h0;
    if (s >= 16 && s < 16 + 2 * N)
      return (s % 2 == 1) ? hi_m[(s - 16) / 2] : lo_m[(s - 16) / 2];
    return 32'h0;
  endfunction

  function automatic string tag_for(int s);
    if (s == 0) return "R2 id";
    if (s == 1) return "R3 version";
    if (s == 2) return "R4 arbitration";
    if (s >= 16 && s < 16 + 2 * N) return "R5 table";
    return "R7 undefined index";
  endfunction

  function automatic logic [31:0] pat(int s);
    logic [7:0] b;
    b = 8'(s);
    return {b ^ 8'h5A, b + 8'h11, ~b, b};
  endfunction

  function automatic logic [7:0] vec_for(int n);
    return 8'(n * 37 + 11);
  endfunction

  task automatic write_index(int s, logic [31:0] d);
    bus_write(8'h00, 8'(s));
    bus_write(8'h10, d);
    if (s == 0) id_m = d[31:24];
    if (s >= 16 && s < 16 + 2 * N) begin
      if (s % 2 == 1) hi_m[(s - 16) / 2] = d;
      else            lo_m[(s - 16) / 2] = d;
    end
  endtask

  task automatic read_index(int s, output logic [31:0] d);
    bus_write(8'h00, 8'(s));
    bus_read(8'h10, d);
  endtask

  // one unmasked line: due two rising edges after it is driven high
  task automatic pulse_line(int n, logic [7:0] exp_vec, bit expect_dlv);
    irq_in[n] = 1'b1;
    step();
    check32(expect_dlv ? "R8 not early" : "R9 masked stage1", {31'h0, dlv_valid}, 32'h0);
    step();
    if (expect_dlv) begin
      check32("R8 valid", {31'h0, dlv_valid}, 32'h1);
      check32("R8 vector", {24'h0, dlv_vector}, {24'h0, exp_vec});
    end else begin
      check32("R9 masked", {31'h0, dlv_valid}, 32'h0);
    end
    for (int k = 0; k < 3; k++) begin
      step();
      check32(expect_dlv ? "R8 held line once" : "R9 masked later", {31'h0, dlv_valid}, 32'h0);
    end
    irq_in[n] = 1'b0;
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    id_m = 8'h00;
    for (int i = 0; i < N; i++) begin
      lo_m[i] = 32'h0001_0000;
      hi_m[i] = 32'h0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R6 reset state
    check32("R6 reset no delivery", {31'h0, dlv_valid}, 32'h0);
    read_index(0, rd);
    check32("R2 id after reset", rd, 32'h0);
    for (int i = 0; i < N; i++) begin
      read_index(16 + 2 * i, rd);
      check32("R6 reset low word masked", rd, 32'h0001_0000);
    end

    // R1 reads away from the window return zero
    bus_read(8'h00, rd); check32("R1 select offset read", rd, 32'h0);
    bus_read(8'h04, rd); check32("R1 offset 04 read", rd, 32'h0);
    bus_read(8'h14, rd); check32("R1 offset 14 read", rd, 32'h0);
    bus_read(8'hFF, rd); check32("R1 offset FF read", rd, 32'h0);

    // R1 stray write does not move the select; R11 read data holds
    bus_write(8'h00, 32'h1);
    bus_write(8'h08, 32'h0000_0002);
    bus_read(8'h10, rd);
    check32("R1 stray write ignored", rd, 32'h0017_0011);
    step();
    check32("R11 read data holds", bus_rdata, 32'h0017_0011);

    // sweep: write every index, then read every index back
    for (int s = 0; s < 256; s++) write_index(s, pat(s));
    for (int s = 0; s < 256; s++) begin
      read_index(s, rd);
      check32(tag_for(s), rd, model_read(s));
    end
    // second pass with inverted patterns
    for (int s = 0; s < 256; s++) write_index(s, ~pat(s));
    for (int s = 0; s < 256; s++) begin
      read_index(s, rd);
      check32(tag_for(s), rd, model_read(s));
    end

    // program every entry unmasked with its own vector
    for (int n = 0; n < N; n++) write_index(16 + 2 * n, {16'h0000, 8'h00, vec_for(n)});
    dlv_ready = 1'b1;
    for (int n = 0; n < N; n++) pulse_line(n, vec_for(n), 1'b1);

    // R9 masked lines deliver nothing
    for (int n = 0; n < N; n += 5) begin
      write_index(16 + 2 * n, {16'h0001, 8'h00, vec_for(n)});
      pulse_line(n, 8'h00, 1'b0);
      write_index(16 + 2 * n, {16'h0000, 8'h00, vec_for(n)});
    end

    // R10 simultaneous rise on 9, 5, 3 with the consumer stalled
    dlv_ready = 1'b0;
    irq_in[9] = 1'b1; irq_in[5] = 1'b1; irq_in[3] = 1'b1;
    step();
    check32("R10 not early", {31'h0, dlv_valid}, 32'h0);
    step();
    check32("R10 first valid", {31'h0, dlv_valid}, 32'h1);
    check32("R10 lowest first", {24'h0, dlv_vector}, {24'h0, vec_for(3)});
    for (int k = 0; k < 3; k++) begin
      step();
      check32("R10 hold valid", {31'h0, dlv_valid}, 32'h1);
      check32("R10 hold vector", {24'h0, dlv_vector}, {24'h0, vec_for(3)});
    end
    dlv_ready = 1'b1;
    step();
    check32("R10 second", {24'h0, dlv_vector}, {24'h0, vec_for(5)});
    check32("R10 second valid", {31'h0, dlv_valid}, 32'h1);
    step();
    check32("R10 third", {24'h0, dlv_vector}, {24'h0, vec_for(9)});
    step();
    check32("R10 drained", {31'h0, dlv_valid}, 32'h0);
    irq_in = '0;
    step();

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule